// File: doc/BRIEF.md
# Fixed-Window Modular Exponentiation Sequencer

The block raises a base to an exponent modulo an odd modulus. It uses the fixed-window (m-ary) method with five-bit digits. A start request captures the three operands. The block then reduces the base modulo the modulus and fills a register table with the 32 powers base^0 to base^31. After that it walks the exponent from its most significant digit to its least significant digit. If the exponent width is not a multiple of five, the top digit is padded with zeros.

For every digit the accumulator, which starts at one, is squared five times. It is then multiplied by the table entry that the digit selects. A zero digit still costs a multiply, by entry 0. This makes the number of operations depend only on the exponent width.

All arithmetic passes through one interleaved shift-add multiplier. The multiplier consumes one operand bit per cycle and keeps its partial result below the modulus by conditional subtraction. The modulus must be odd and greater than one.

Top module: `modexp_fw`

## Requirements
- R1: After reset, `done` is low and `result` is zero.
- R2: For an odd modulus k > 1 and any base a and exponent b, including a >= k and the all-ones exponent, the completed `result` equals a^b mod k.
- R3: An exponent of zero gives a result of 1, whatever the base, including a base of zero.
- R4: A base of zero (or a base equal to the modulus) with a nonzero exponent gives a result of 0.
- R5: A base of k-1 gives 1 for an even exponent and k-1 for an odd exponent.
- R6: `done` rises exactly (2^W - 1 + ceil(EW/W)*(W+1)) * MW clock edges after the edge that accepts `start`. That is 880 edges for the defaults, for any operand values.
- R7: `done` is high for a single cycle per operation. `result` changes only in that cycle and then holds until the next completion.
- R8: A `start` pulse while an operation is running is ignored. That operation finishes on schedule with the operands it captured, and it produces exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture operands and begin, when idle |
| base | input | MW | Base a |
| expo | input | EW | Exponent b |
| modulus | input | MW | Odd modulus k > 1 |
| result | output | MW | Last computed a^b mod k |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can happen in the same clock cycle: a new `start` request and a computation that is still in progress. The bench provokes this by pulsing `start` with different operands partway through a run. It then judges the outcome by three checks: the result must still match the first operands, the latency must stay at the fixed count, and exactly one completion may occur. The bench also launches back-to-back operations right after a `done`. This confirms that a request arriving just after completion is accepted rather than lost.

// File: rtl/modexp_fw.sv
module modexp_fw #(
  parameter int MW = 16,
  parameter int EW = 20,
  parameter int W  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] base,
  input  logic [EW-1:0] expo,
  input  logic [MW-1:0] modulus,
  output logic [MW-1:0] result,
  output logic          done
);
  localparam int TN = 1 << W;
  localparam int ND = (EW + W - 1) / W;
  localparam int PW = ND * W;
  localparam int CW = (MW > 1) ? $clog2(MW) : 1;
  localparam int DW = (ND > 1) ? $clog2(ND) : 1;
  localparam int SW = $clog2(W + 1);

  typedef enum logic [1:0] {IDLE, RED, TAB, EXPN} st_t;

  st_t            st;
  logic [MW-1:0]  km, ab, mx, my, mr;
  logic [PW-1:0]  ep;
  logic [CW-1:0]  mcnt;
  logic [W-1:0]   tidx;
  logic [DW-1:0]  didx;
  logic [SW-1:0]  sqc;
  logic [MW-1:0]  tbl [TN];
  logic           busy, mul_last;

  logic [MW:0]    t1, t2, s1, s2;
  logic [MW-1:0]  nr;
  logic [W-1:0]   digit;

  assign busy     = (st != IDLE);
  assign mul_last = busy && (mcnt == '0);
  assign t1       = {mr, 1'b0};
  assign t2       = (t1 >= {1'b0, km}) ? t1 - {1'b0, km} : t1;
  assign s1       = t2 + (my[mcnt] ? {1'b0, mx} : '0);
  assign s2       = (s1 >= {1'b0, km}) ? s1 - {1'b0, km} : s1;
  assign nr       = s2[MW-1:0];
  assign digit    = ep[didx*W +: W];

  always_ff @(posedge clk) begin
    if (!busy && start) tbl[0] <= MW'(1);
    if (mul_last && st == RED) tbl[1] <= nr;
    if (mul_last && st == TAB) tbl[tidx] <= nr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; km <= '0; ab <= '0; mx <= '0; my <= '0; mr <= '0;
      ep <= '0; mcnt <= '0; tidx <= '0; didx <= '0; sqc <= '0;
      result <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          km <= modulus; ep <= PW'(expo);
          mx <= MW'(1); my <= base; mr <= '0;
          mcnt <= CW'(MW - 1); st <= RED;
        end
      end else if (mcnt != '0) begin
        mr <= nr;
        mcnt <= mcnt - 1'b1;
      end else begin
        mr <= '0;
        mcnt <= CW'(MW - 1);
        case (st)
          RED: begin
            ab <= nr; mx <= nr; my <= nr;
            tidx <= W'(2); st <= TAB;
          end
          TAB: begin
            if (tidx == W'(TN - 1)) begin
              mx <= MW'(1); my <= MW'(1);
              didx <= DW'(ND - 1); sqc <= '0; st <= EXPN;
            end else begin
              mx <= nr; my <= ab; tidx <= tidx + 1'b1;
            end
          end
          default: begin
            if (sqc < SW'(W - 1)) begin
              mx <= nr; my <= nr; sqc <= sqc + 1'b1;
            end else if (sqc == SW'(W - 1)) begin
              mx <= nr; my <= tbl[digit]; sqc <= SW'(W);
            end else if (didx == '0) begin
              result <= nr; done <= 1'b1; st <= IDLE;
            end else begin
              didx <= didx - 1'b1; sqc <= '0;
              mx <= nr; my <= nr;
            end
          end
        endcase
      end
    end
  end
endmodule

module modexp_fw_chk #(
  parameter int MW = 16,
  parameter int EW = 20,
  parameter int W  = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [MW-1:0] result,
  input logic [MW-1:0] km
);
  localparam int ND = (EW + W - 1) / W;
  localparam int LAT = ((1 << W) - 1 + ND * (W + 1)) * MW;

  int unsigned cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 0;
    else if (start && !busy) cnt <= 0;
    else cnt <= cnt + 1;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> done);
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> $stable(km));
  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cnt == LAT));
endmodule

bind modexp_fw modexp_fw_chk #(.MW(MW), .EW(EW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .result(result), .km(km)
);

// File: tb/test_modexp_fw.sv
module test_modexp_fw;
  localparam int MW = 16;
  localparam int EW = 20;
  localparam int W = 5;
  localparam int LAT = ((1 << W) - 1 + ((EW + W - 1) / W) * (W + 1)) * MW;

  logic clk = 0, rst_n = 0, start = 0, done;
  logic [MW-1:0] base = 0, modulus = 3, result;
  logic [EW-1:0] expo = 0;

  int total = 0, fails = 0;
  int unsigned edges = 0;
  logic [MW-1:0] exp_q[$];
  string tag_q[$];
  logic prev_done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  modexp_fw #(.MW(MW), .EW(EW), .W(W)) i_modexp_fw (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .expo(expo),
    .modulus(modulus), .result(result), .done(done)
  );

  function automatic logic [MW-1:0] ref_pow(logic [MW-1:0] a, logic [EW-1:0] b, logic [MW-1:0] k);
    longint r = 1;
    longint x = longint'(a) % longint'(k);
    for (int i = EW - 1; i >= 0; i--) begin
      r = (r * r) % longint'(k);
      if (b[i]) r = (r * x) % longint'(k);
    end
    return MW'(r);
  endfunction

  task automatic check(input string req, input longint act, input longint expv);
    total++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) check("R7 pulse width", 2, 1);
      if (done) begin
        if (exp_q.size() == 0) check("R8 extra done", 1, 0);
        else begin
          logic [MW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, result, e);
        end
      end
    end
    prev_done = done;
  end

  task automatic run_op(input logic [MW-1:0] a, input logic [EW-1:0] b,
                        input logic [MW-1:0] k, input string tag, input bit poke);
    int unsigned t0;
    int waited;
    logic [MW-1:0] e;
    e = ref_pow(a, b, k);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    base = a; expo = b; modulus = k; start = 1;
    @(negedge clk);
    start = 0;
    t0 = edges;
    waited = 0;
    while (!done) begin
      @(negedge clk);
      waited++;
      if (poke && waited == 100) begin
        base = ~a; expo = ~b; modulus = k ^ 16'h0002; start = 1;
      end else start = 0;
    end
    check(poke ? "R8 latency with ignored start" : "R6 latency", edges - t0, LAT);
    repeat (3) @(negedge clk);
    check("R7 result holds", result, e);
  endtask

  initial begin
    #(200000 * 20);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 done after reset", done, 0);
    check("R1 result after reset", result, 0);
    run_op(16'd7, 20'd0, 16'd13, "R3 exponent zero", 0);
    run_op(16'd0, 20'd0, 16'd101, "R3 zero to zero", 0);
    run_op(16'd0, 20'd5, 16'd101, "R4 base zero", 0);
    run_op(16'd101, 20'd9, 16'd101, "R4 base equals modulus", 0);
    run_op(16'd100, 20'd6, 16'd101, "R5 k-1 even exponent", 0);
    run_op(16'd100, 20'd77, 16'd101, "R5 k-1 odd exponent", 0);
    run_op(16'hFFFE, 20'hFFFFF, 16'hFFFF, "R2 all-ones exponent", 0);
    run_op(16'hF123, 20'h12345, 16'd3, "R2 base above modulus", 0);
    run_op(16'd2, 20'd31, 16'd65521, "R2 single digit", 0);
    run_op(16'd3, 20'h80000, 16'd40961, "R2 top bit only", 0);
    run_op(16'd12345, 20'h54321, 16'd54321, "R8 busy start", 1);
    for (int i = 0; i < 6; i++) begin
      logic [MW-1:0] a, k;
      logic [EW-1:0] b;
      a = MW'($urandom);
      b = EW'($urandom);
      k = MW'($urandom) | 16'h0001;
      if (k == 16'd1) k = 16'd7;
      run_op(a, b, k, "R2 random", 0);
    end
    repeat (4) @(negedge clk);
    check("R8 queue drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule